// File: doc/BRIEF.md
# Palette Entry Converter

This block turns raw colour-lookup entries, streamed in from memory as 32-bit words, into one internal form: an 8-bit red, green and blue value plus a transparency flag. Each converted entry leaves on a write port (index, colour, flag) that feeds a palette RAM. The number of entries depends on the pixel depth of the frame, and four source encodings are supported. Two of them use 16-bit entries and two use 32-bit entries. A monochrome mode replaces the colour fields with a gray level.

A conversion is requested with a one-cycle `frame_start`. It runs only when the depth uses a palette and either the frame asks for a palette load or the encoding differs from the one used in the last conversion. Otherwise the request is dropped. While a conversion runs, `busy` is high and the block takes words through a valid/ready pair. For 16-bit encodings each word carries two entries.

Top module: `pal_convert`

## Requirements
- R1: After reset, `busy`, `wr_en` and `in_ready` are low.
- R2: Depth code 1 gives 4 entries, code 2 gives 16 and code 3 gives 256. They are written with indices 0 upward, one per write. Any other depth code starts no conversion and makes no writes.
- R3: Encoding 0 takes a 16-bit entry: red from bits 15:11, green from bits 10:5 and blue from bits 4:0. Each field is placed at the top of its 8-bit channel and the lower bits are zero. Transparency is 0.
- R4: Encoding 1 decodes colour exactly as encoding 0. Its flag position (bit 24) lies outside a 16-bit entry, so transparency is always 0.
- R5: Encoding 2 takes a 32-bit entry: red from bits 23:19, green from bits 15:10 and blue from bits 7:3, each placed at the top of its channel with zeros below. Transparency is bit 24.
- R6: Encoding 3 takes a 32-bit entry: red from bits 23:16, green from bits 15:8 and blue from bits 7:0. Transparency is bit 24.
- R7: With `mono` high, bits 7:0 of the entry go to red, green and blue alike. Transparency still follows the encoding.
- R8: For encodings 0 and 1, the first entry of a word is bits 15:0 and the second is bits 31:16. `in_ready` is low while the low half is being used and high while the high half is being used. For encodings 2 and 3, `in_ready` stays high for the whole conversion.
- R9: An idle `frame_start` with a palette depth starts a conversion if `load_req` is high, or if no conversion has run since reset, or if `fmt_sel` differs from the encoding of the last conversion. In every other case it is ignored.
- R10: `busy` rises one cycle after an accepted `frame_start` and stays high through the cycle of the last write, then falls. A `frame_start` while busy is ignored. Encoding and mono mode are latched at the start of a conversion.
- R11: While `in_valid` is low during a conversion, no entry is written and no progress is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_start | input | 1 | One-cycle request to convert |
| load_req | input | 1 | Frame asks for a palette load |
| depth_sel | input | 3 | Pixel depth code (1, 2, 3 use a palette) |
| fmt_sel | input | 2 | Source entry encoding 0..3 |
| mono | input | 1 | Force gray output from the entry's low byte |
| in_valid | input | 1 | Input word present |
| in_data | input | 32 | Input word |
| in_ready | output | 1 | Input word consumed at this edge |
| busy | output | 1 | Conversion in progress |
| wr_en | output | 1 | Palette RAM write strobe |
| wr_idx | output | IDX_W | Palette RAM index |
| wr_red | output | 8 | Red channel |
| wr_green | output | 8 | Green channel |
| wr_blue | output | 8 | Blue channel |
| wr_alpha | output | 1 | Transparency flag |

## Verification
The internal state that can go wrong is the latched encoding, the half-word selector, the entry index and the stored last encoding. A wrong half selector shows on the very next write as swapped colour data, and also as `in_ready` high on a low half. A wrong index or entry count shows as a skipped or repeated `wr_idx`, or as a missing or extra write before `busy` falls. A corrupted last encoding shows only at the next `frame_start`, where a conversion starts or fails to start against the rule in R9. The scoreboard compares every written entry against a model of the requirements. Runs without `load_req` check that the trigger rule holds.

// File: rtl/pal_pkg.sv
package pal_pkg;
    localparam int WORD_W = 32;
    localparam int HALF_W = 16;
    localparam int CH_W   = 8;

    typedef enum logic [1:0] {
        FMT_565  = 2'd0,
        FMT_565T = 2'd1,
        FMT_666T = 2'd2,
        FMT_888T = 2'd3
    } pal_fmt_e;

    typedef struct packed {
        logic [CH_W-1:0] r;
        logic [CH_W-1:0] g;
        logic [CH_W-1:0] b;
        logic            a;
    } pal_px_t;

    // number of palette entries for a pixel-depth code; zero when unpaletted
    function automatic int unsigned pal_entries(logic [2:0] depth);
        case (depth)
            3'd1:    return 4;
            3'd2:    return 16;
            3'd3:    return 256;
            default: return 0;
        endcase
    endfunction

    function automatic logic fmt_is_wide(pal_fmt_e f);
        return f[1];
    endfunction
endpackage

// File: rtl/pal_lane_mux.sv
module pal_lane_mux
    import pal_pkg::*;
(
    input  logic              wide,
    input  logic              half,
    input  logic [WORD_W-1:0] word,
    output logic [WORD_W-1:0] entry
);
    always_comb begin
        if (wide) begin
            entry = word;
        end else if (half) begin
            entry = {{(WORD_W-HALF_W){1'b0}}, word[WORD_W-1:HALF_W]};
        end else begin
            entry = {{(WORD_W-HALF_W){1'b0}}, word[HALF_W-1:0]};
        end
    end
endmodule

// File: rtl/pal_entry_decode.sv
module pal_entry_decode
    import pal_pkg::*;
(
    input  pal_fmt_e          fmt,
    input  logic              mono,
    input  logic [WORD_W-1:0] entry,
    output pal_px_t           px
);
    always_comb begin
        px = '0;
        case (fmt)
            FMT_565, FMT_565T: begin
                px.r = {entry[15:11], 3'b000};
                px.g = {entry[10:5],  2'b00};
                px.b = {entry[4:0],   3'b000};
                px.a = 1'b0;
            end
            FMT_666T: begin
                px.r = {entry[23:19], 3'b000};
                px.g = {entry[15:10], 2'b00};
                px.b = {entry[7:3],   3'b000};
                px.a = entry[24];
            end
            default: begin
                px.r = entry[23:16];
                px.g = entry[15:8];
                px.b = entry[7:0];
                px.a = entry[24];
            end
        endcase
        if (mono) begin
            px.r = entry[CH_W-1:0];
            px.g = entry[CH_W-1:0];
            px.b = entry[CH_W-1:0];
        end
    end
endmodule

// File: rtl/pal_seq.sv
module pal_seq
    import pal_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start,
    input  logic             load_req,
    input  logic [2:0]       depth_sel,
    input  pal_fmt_e         fmt_sel,
    input  logic             mono_in,
    input  logic             in_valid,
    input  pal_px_t          dec_px,
    output logic             half_o,
    output pal_fmt_e         fmt_o,
    output logic             mono_o,
    output logic             in_ready,
    output logic             busy,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output pal_px_t          wr_px
);
    typedef struct packed {
        logic             run;
        logic             half;
        logic [IDX_W-1:0] idx;
        logic [IDX_W-1:0] last_idx;
        pal_fmt_e         fmt;
        logic             mono;
        pal_fmt_e         last_fmt;
        logic             fmt_known;
        logic             wr_en;
        logic [IDX_W-1:0] wr_idx;
        pal_px_t          wr_px;
    } seq_t;

    seq_t s_d, s_q;
    int unsigned n_ent;
    logic        fmt_new;
    logic        wide_q;

    assign wide_q = fmt_is_wide(s_q.fmt);

    always_comb begin
        s_d       = s_q;
        s_d.wr_en = 1'b0;
        n_ent     = pal_entries(depth_sel);
        fmt_new   = !s_q.fmt_known || (fmt_sel != s_q.last_fmt);
        if (!s_q.run) begin
            if (frame_start && !s_q.wr_en && (n_ent != 0) && (load_req || fmt_new)) begin
                s_d.run       = 1'b1;
                s_d.half      = 1'b0;
                s_d.idx       = '0;
                s_d.last_idx  = IDX_W'(n_ent - 1);
                s_d.fmt       = fmt_sel;
                s_d.mono      = mono_in;
                s_d.last_fmt  = fmt_sel;
                s_d.fmt_known = 1'b1;
            end
        end else if (in_valid) begin
            s_d.wr_en  = 1'b1;
            s_d.wr_idx = s_q.idx;
            s_d.wr_px  = dec_px;
            s_d.idx    = s_q.idx + 1'b1;
            if (!wide_q) begin
                s_d.half = ~s_q.half;
            end
            if (s_q.idx == s_q.last_idx) begin
                s_d.run = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign half_o   = s_q.half;
    assign fmt_o    = s_q.fmt;
    assign mono_o   = s_q.mono;
    assign in_ready = s_q.run && (wide_q || s_q.half);
    assign busy     = s_q.run || s_q.wr_en;
    assign wr_en    = s_q.wr_en;
    assign wr_idx   = s_q.wr_idx;
    assign wr_px    = s_q.wr_px;
endmodule

// File: rtl/pal_convert.sv
module pal_convert
    import pal_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              load_req,
    input  logic [2:0]        depth_sel,
    input  logic [1:0]        fmt_sel,
    input  logic              mono,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_data,
    output logic              in_ready,
    output logic              busy,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [CH_W-1:0]   wr_red,
    output logic [CH_W-1:0]   wr_green,
    output logic [CH_W-1:0]   wr_blue,
    output logic              wr_alpha
);
    logic              half_q;
    pal_fmt_e          fmt_q;
    logic              mono_q;
    logic [WORD_W-1:0] entry;
    pal_px_t           dec_px;
    pal_px_t           px_q;

    pal_lane_mux u_lane (
        .wide  (fmt_is_wide(fmt_q)),
        .half  (half_q),
        .word  (in_data),
        .entry (entry)
    );

    pal_entry_decode u_dec (
        .fmt   (fmt_q),
        .mono  (mono_q),
        .entry (entry),
        .px    (dec_px)
    );

    pal_seq #(.IDX_W(IDX_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .load_req    (load_req),
        .depth_sel   (depth_sel),
        .fmt_sel     (pal_fmt_e'(fmt_sel)),
        .mono_in     (mono),
        .in_valid    (in_valid),
        .dec_px      (dec_px),
        .half_o      (half_q),
        .fmt_o       (fmt_q),
        .mono_o      (mono_q),
        .in_ready    (in_ready),
        .busy        (busy),
        .wr_en       (wr_en),
        .wr_idx      (wr_idx),
        .wr_px       (px_q)
    );

    assign wr_red   = px_q.r;
    assign wr_green = px_q.g;
    assign wr_blue  = px_q.b;
    assign wr_alpha = px_q.a;
endmodule

// File: rtl/pal_convert_chk.sv
module pal_convert_chk #(
    parameter int IDX_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             wr_en,
    input logic [IDX_W-1:0] wr_idx,
    input logic             in_ready,
    input logic             in_valid
);
    AST_WRITE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> busy); // R10

    AST_READY_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> busy); // R8

    AST_WRITE_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(in_valid)); // R11

    AST_IDX_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $past(wr_en)) |-> (wr_idx == IDX_W'($past(wr_idx) + 1'b1))); // R2

    AST_BUSY_ENDS_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(wr_en)); // R10
endmodule

bind pal_convert pal_convert_chk #(.IDX_W(IDX_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .in_ready (in_ready),
    .in_valid (in_valid)
);

// File: tb/pal_convert_tb_top.sv
module pal_convert_tb_top;
    import pal_pkg::*;
    localparam int IDX_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              frame_start = 1'b0;
    logic              load_req = 1'b0;
    logic [2:0]        depth_sel = 3'd0;
    logic [1:0]        fmt_sel = 2'd0;
    logic              mono = 1'b0;
    logic              in_valid = 1'b0;
    logic [WORD_W-1:0] in_data = '0;
    logic              in_ready, busy, wr_en, wr_alpha;
    logic [IDX_W-1:0]  wr_idx;
    logic [CH_W-1:0]   wr_red, wr_green, wr_blue;

    always #4 clk = ~clk;

    pal_convert #(.IDX_W(IDX_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .load_req(load_req),
        .depth_sel(depth_sel), .fmt_sel(fmt_sel), .mono(mono), .in_valid(in_valid),
        .in_data(in_data), .in_ready(in_ready), .busy(busy), .wr_en(wr_en),
        .wr_idx(wr_idx), .wr_red(wr_red), .wr_green(wr_green), .wr_blue(wr_blue),
        .wr_alpha(wr_alpha)
    );

    typedef struct {
        int      idx;
        pal_px_t px;
        string   tag;
    } exp_t;

    exp_t sb[$];
    int checks = 0;
    int fails  = 0;

    function automatic pal_px_t model(int fmt, bit m, logic [31:0] e);
        pal_px_t p;
        if (fmt < 2) begin
            p.r = {e[15:11], 3'b0}; p.g = {e[10:5], 2'b0}; p.b = {e[4:0], 3'b0}; p.a = 1'b0;
        end else if (fmt == 2) begin
            p.r = {e[23:19], 3'b0}; p.g = {e[15:10], 2'b0}; p.b = {e[7:3], 3'b0}; p.a = e[24];
        end else begin
            p.r = e[23:16]; p.g = e[15:8]; p.b = e[7:0]; p.a = e[24];
        end
        if (m) begin
            p.r = e[7:0]; p.g = e[7:0]; p.b = e[7:0];
        end
        return p;
    endfunction

    task automatic check(bit ok, string tag, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && wr_en) begin
            if (sb.size() == 0) begin
                check(1'b0, "R2/R9", "unexpected write idx", int'(wr_idx), -1);
            end else begin
                exp_t e;
                pal_px_t got;
                e = sb.pop_front();
                got = '{r: wr_red, g: wr_green, b: wr_blue, a: wr_alpha};
                check(int'(wr_idx) == e.idx, e.tag, "wr_idx", int'(wr_idx), e.idx);
                check(got == e.px, e.tag, "entry", int'(got), int'(e.px));
                check(busy == 1'b1, "R10", "busy during write", int'(busy), 1);
            end
        end
    end

    function automatic logic [31:0] gen(int seed, int i);
        return (32'(seed) * 32'h0100_0193) ^ (32'(i) * 32'h9E37_79B9) ^ 32'h5A3C_0F96;
    endfunction

    task automatic send_word(logic [31:0] w, bit narrow);
        bit r;
        in_valid = 1'b1;
        in_data  = w;
        if (narrow) check(in_ready == 1'b0, "R8", "ready on low half", int'(in_ready), 0);
        while (1) begin
            r = in_ready;
            @(negedge clk);
            if (r) break;
        end
    endtask

    task automatic run_conv(int depth, int fmt, bit m, bit load, int seed,
                            bit gaps, bit poke, bit expect_conv, string tag);
        int n;
        bit narrow;
        @(negedge clk);
        frame_start = 1'b1; load_req = load; depth_sel = 3'(depth);
        fmt_sel = 2'(fmt); mono = m;
        @(negedge clk);
        frame_start = 1'b0; load_req = 1'b0;
        if (!expect_conv) begin
            check(busy == 1'b0, tag, "busy on ignored start", int'(busy), 0);
            in_valid = 1'b1; in_data = gen(seed, 0);
            repeat (4) @(negedge clk);
            check(in_ready == 1'b0, tag, "ready on ignored start", int'(in_ready), 0);
            in_valid = 1'b0;
            return;
        end
        check(busy == 1'b1, "R10", "busy after start", int'(busy), 1);
        n = (depth == 1) ? 4 : (depth == 2) ? 16 : 256;
        narrow = (fmt < 2);
        for (int i = 0; i < n; i++) begin
            logic [31:0] w = gen(seed, narrow ? i / 2 : i);
            logic [31:0] e = narrow ? (i[0] ? {16'h0, w[31:16]} : {16'h0, w[15:0]}) : w;
            exp_t x;
            x.idx = i; x.px = model(fmt, m, e); x.tag = narrow ? {tag, "/R8"} : tag;
            sb.push_back(x);
        end
        for (int k = 0; k < (narrow ? n / 2 : n); k++) begin
            send_word(gen(seed, k), narrow);
            if (gaps) begin
                in_valid = 1'b0;
                in_data  = 32'hFFFF_FFFF;
                repeat (3) @(negedge clk);
            end
            if (poke && k == 0) begin
                in_valid = 1'b0;
                frame_start = 1'b1; load_req = 1'b1; fmt_sel = 2'(fmt ^ 3); mono = ~m;
                @(negedge clk);
                frame_start = 1'b0; load_req = 1'b0; fmt_sel = 2'(fmt); mono = m;
            end
        end
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        check(busy == 1'b0, "R10", "busy after last write", int'(busy), 0);
        check(sb.size() == 0, "R2", "entries left", sb.size(), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(busy == 1'b0 && wr_en == 1'b0 && in_ready == 1'b0, "R1", "reset outputs",
              int'({busy, wr_en, in_ready}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 1'b0 && wr_en == 1'b0 && in_ready == 1'b0, "R1", "idle outputs",
              int'({busy, wr_en, in_ready}), 0);
        run_conv(1, 0, 1'b0, 1'b1, 11, 1'b0, 1'b0, 1'b1, "R3");
        run_conv(2, 1, 1'b0, 1'b1, 22, 1'b0, 1'b0, 1'b1, "R4");
        run_conv(2, 2, 1'b0, 1'b1, 33, 1'b1, 1'b0, 1'b1, "R5/R11");
        run_conv(3, 3, 1'b0, 1'b1, 44, 1'b0, 1'b0, 1'b1, "R6/R2");
        run_conv(1, 3, 1'b0, 1'b0, 55, 1'b0, 1'b0, 1'b0, "R9");
        run_conv(1, 0, 1'b0, 1'b0, 66, 1'b0, 1'b0, 1'b1, "R9");
        run_conv(1, 0, 1'b1, 1'b1, 77, 1'b0, 1'b0, 1'b1, "R7");
        run_conv(2, 3, 1'b1, 1'b1, 88, 1'b0, 1'b1, 1'b1, "R7/R10");
        run_conv(2, 3, 1'b0, 1'b0, 99, 1'b0, 1'b0, 1'b0, "R10");
        run_conv(5, 2, 1'b0, 1'b1, 12, 1'b0, 1'b0, 1'b0, "R2");
        run_conv(0, 1, 1'b0, 1'b1, 13, 1'b0, 1'b0, 1'b0, "R2");
        run_conv(2, 2, 1'b0, 1'b0, 14, 1'b0, 1'b0, 1'b1, "R9");
        repeat (4) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule